// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block picks the divider settings for a frequency synthesizer that has a reference divider M, a feedback multiplier N and an output post-divider chosen by a 4-bit code. A caller gives a requested output frequency and the reference frequency, both in kHz, along with limits on the VCO range, the comparison frequency (reference divided by M), M and N, and then pulses `start`. The engine runs a bounded search and reports the best M, N and post-divider code it found. It also reports the output frequency those settings give and whether the match is exact.

All arithmetic inside is done internally at twice the requested rate. The engine first derives the range of post-divider codes worth trying. It then sweeps codes upward and, inside each code, sweeps M upward. For each M it tries the two N values that bracket the ideal one, and scores every legal candidate by its rounded output error. The search stops on the first zero-error candidate. Every quotient comes from one shared restoring divider that takes several cycles, so a search takes from a few hundred to a few thousand clock cycles, depending on how many candidates are visited. The limit inputs must stay stable while `busy` is high. `mMin` must be at least 1 and no larger than `mMax`.

Top module: `pll_coef_search`

## Requirements
- R1: Post-divider codes 0 to 14 select divide ratios 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32 in that code order. The reported code and the achieved frequency follow this table.
- R2: With T = 2 × request and padded P = T + floor(T/50), the top ratio is ceil(max(vcoMax, P)/P) and the bottom ratio is floor(vcoMin/P), each clamped to [1, 32]. Each is turned into a code by taking the lowest code from 0 to 13 whose ratio is at least that value, or code 14 if none is. Codes are tried from the bottom code up to the top code.
- R3: Within each code, M runs upward from mMin to mMax. A candidate replaces the current best only when its error is strictly smaller, so on a tie the earliest candidate is kept.
- R4: If ref/M (floored) is below cmpMin, the M sweep for the current code ends. If ref/M is above cmpMax, that M is skipped.
- R5: For each M, N takes floor and then ceil of T×ratio×M/ref. If the floor exceeds nMax, the M sweep for the current code ends. An N below nMin is skipped, and an N above nMax ends the N trials for that M.
- R6: A candidate is legal only if floor(ref×N/M) lies within [vcoMin, max(vcoMax, P)]. A request above the VCO maximum therefore widens the top of the window.
- R7: The error of a candidate is |floor((V + floor(ratio/2))/ratio) − T|. The search stops at the first candidate with zero error. `exact` is 1 exactly when the reported best has zero error.
- R8: If no candidate is legal, the outputs are M = mMax, N = nMin, code 1 and `exact` = 0.
- R9: `rateKhz` equals floor(floor(ref×N/(M×ratio))/2) for the reported M, N and code.
- R10: `done` is a one-cycle pulse, raised once all outputs are final. `busy` is high from the cycle after an accepted start through the `done` cycle. Outputs hold their values while idle. After reset every output is 0.
- R11: A `start` while `busy` is high is ignored. The request and the reference are captured only at an accepted start, so a later change on those inputs does not affect the running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only while idle) |
| targetKhz | input | FW | Requested output frequency, kHz |
| refKhz | input | FW | Reference frequency, kHz |
| vcoMinKhz | input | FW | Lowest allowed VCO frequency, kHz |
| vcoMaxKhz | input | FW | Highest allowed VCO frequency, kHz |
| cmpMinKhz | input | FW | Lowest allowed ref/M, kHz |
| cmpMaxKhz | input | FW | Highest allowed ref/M, kHz |
| mMin | input | MW | Smallest reference divider |
| mMax | input | MW | Largest reference divider |
| nMin | input | NW | Smallest feedback multiplier |
| nMax | input | NW | Largest feedback multiplier |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result-ready pulse |
| mOut | output | MW | Chosen reference divider |
| nOut | output | NW | Chosen feedback multiplier |
| plOut | output | 4 | Chosen post-divider code |
| rateKhz | output | FW | Output frequency of the chosen settings, kHz |
| exact | output | 1 | Chosen settings hit the target with zero error |

## Verification
The hardest outcome to reach from the ports is the fallback result. Under default limits nearly every request finds some legal candidate, so the fallback never shows up on its own. The bench reaches it by narrowing nMax so far that the floor N exceeds it for every code, and it also checks the fixed fallback values directly. It likewise narrows the comparison window and raises nMin to force the skip and break paths. It then sweeps several references against requests whose code ranges fall in the non-monotonic tail of the ratio table and above the VCO maximum. Finally it re-pulses `start` mid-search with a different request to show that the first search is left unchanged.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned RATIO_W   = 6;
  localparam int unsigned LAST_CODE = 14;

  typedef enum logic [2:0] {
    OP_PAD, OP_HI, OP_LO, OP_CMP, OP_NF, OP_VCO, OP_LWV, OP_RATE
  } divOp_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic   clear;
    logic   divGo;
    logic   take;
    divOp_e op;
    logic   plLoad;
    logic   plInc;
    logic   mLoad;
    logic   mInc;
    logic   nInc;
  } ctlStrobe_t;

  function automatic logic [RATIO_W-1:0] ratioOf(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    ratioOf = 6'd1;
      4'd1:    ratioOf = 6'd2;
      4'd2:    ratioOf = 6'd3;
      4'd3:    ratioOf = 6'd4;
      4'd4:    ratioOf = 6'd5;
      4'd5:    ratioOf = 6'd6;
      4'd6:    ratioOf = 6'd8;
      4'd7:    ratioOf = 6'd10;
      4'd8:    ratioOf = 6'd12;
      4'd9:    ratioOf = 6'd16;
      4'd10:   ratioOf = 6'd12;
      4'd11:   ratioOf = 6'd16;
      4'd12:   ratioOf = 6'd20;
      4'd13:   ratioOf = 6'd24;
      4'd14:   ratioOf = 6'd32;
      default: ratioOf = 6'd1;
    endcase
  endfunction

  // Lowest code whose ratio reaches the wanted value; last code otherwise
  function automatic logic [CODE_W-1:0] codeFor(input logic [RATIO_W-1:0] want);
    logic hit;
    hit = 1'b0;
    codeFor = CODE_W'(LAST_CODE);
    for (int c = 0; c < LAST_CODE; c++) begin
      if (!hit && ratioOf(CODE_W'(c)) >= want) begin
        codeFor = CODE_W'(c);
        hit = 1'b1;
      end
    end
  endfunction

endpackage

// File: rtl/pcs_divider.sv
module pcs_divider #(
  parameter int unsigned DW = 48
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] remd
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] dvsr;
  logic [DW:0]   trial;

  always_comb trial = {remd, quot[DW-1]} - {1'b0, dvsr};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      dvsr <= '0;
      quot <= '0;
      remd <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && cnt == '0) begin
        dvsr <= divisor;
        quot <= dividend;
        remd <= '0;
        cnt  <= CW'(DW);
      end else if (cnt != '0) begin
        if (trial[DW]) begin
          remd <= {remd[DW-2:0], quot[DW-1]};
          quot <= {quot[DW-2:0], 1'b0};
        end else begin
          remd <= trial[DW-1:0];
          quot <= {quot[DW-2:0], 1'b1};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcs_dpath.sv
module pcs_dpath
  import pcs_pkg::*;
#(
  parameter int unsigned FW   = 24,
  parameter int unsigned MW   = 8,
  parameter int unsigned NW   = 8,
  parameter int unsigned RMIN = 1,
  parameter int unsigned RMAX = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        s,
  input  logic [FW-1:0]     targetKhz,
  input  logic [FW-1:0]     refKhz,
  input  logic [FW-1:0]     vcoMinKhz,
  input  logic [FW-1:0]     vcoMaxKhz,
  input  logic [FW-1:0]     cmpMinKhz,
  input  logic [FW-1:0]     cmpMaxKhz,
  input  logic [MW-1:0]     mMin,
  input  logic [MW-1:0]     mMax,
  input  logic [NW-1:0]     nMin,
  input  logic [NW-1:0]     nMax,
  output logic              divDone,
  output logic              qLtCmpMin,
  output logic              qGtCmpMax,
  output logic              qGtNMax,
  output logic              qInVco,
  output logic              hitZero,
  output logic              nAboveHi,
  output logic              nBelowMin,
  output logic              nAboveMax,
  output logic              mLast,
  output logic              plLast,
  output logic              plEmpty,
  output logic [MW-1:0]     mOut,
  output logic [NW-1:0]     nOut,
  output logic [CODE_W-1:0] plOut,
  output logic [FW-1:0]     rateKhz,
  output logic              exact
);
  localparam int unsigned DW  = 2 * FW;
  localparam int unsigned NHW = NW + 1;

  logic [DW-1:0]      tgt, refR, pad, vco, vmaxEff, bestDelta, delta;
  logic [DW-1:0]      opA, opB, quot, remd;
  logic [CODE_W-1:0]  hiCode, loCode, pl, bestPl;
  logic [MW-1:0]      m, bestM;
  logic [NHW-1:0]     n, nHi;
  logic [NW-1:0]      bestN;
  logic [RATIO_W-1:0] ratio, bestRatio;
  logic [FW-1:0]      rateR;

  function automatic logic [RATIO_W-1:0] clampRatio(input logic [DW-1:0] q);
    if (q < DW'(RMIN))      clampRatio = RATIO_W'(RMIN);
    else if (q > DW'(RMAX)) clampRatio = RATIO_W'(RMAX);
    else                    clampRatio = q[RATIO_W-1:0];
  endfunction

  always_comb begin
    ratio     = ratioOf(pl);
    bestRatio = ratioOf(bestPl);
    vmaxEff   = (DW'(vcoMaxKhz) > pad) ? DW'(vcoMaxKhz) : pad;
    delta     = (quot >= tgt) ? quot - tgt : tgt - quot;
    unique case (s.op)
      OP_PAD:  begin opA = tgt;                           opB = DW'(50); end
      OP_HI:   begin opA = vmaxEff + pad - 1'b1;          opB = pad; end
      OP_LO:   begin opA = DW'(vcoMinKhz);                opB = pad; end
      OP_CMP:  begin opA = refR;                          opB = DW'(m); end
      OP_NF:   begin opA = tgt * DW'(ratio) * DW'(m);     opB = refR; end
      OP_VCO:  begin opA = refR * DW'(n);                 opB = DW'(m); end
      OP_LWV:  begin opA = vco + DW'(ratio >> 1);         opB = DW'(ratio); end
      default: begin opA = refR * DW'(bestN);             opB = DW'(bestM) * DW'(bestRatio); end
    endcase
  end

  pcs_divider #(.DW(DW)) uDiv (
    .clk(clk), .rstN(rstN), .go(s.divGo),
    .dividend(opA), .divisor(opB),
    .done(divDone), .quot(quot), .remd(remd)
  );

  always_comb begin
    qLtCmpMin = quot < DW'(cmpMinKhz);
    qGtCmpMax = quot > DW'(cmpMaxKhz);
    qGtNMax   = quot > DW'(nMax);
    qInVco    = (quot >= DW'(vcoMinKhz)) && (quot <= vmaxEff);
    hitZero   = (quot == tgt);
    nAboveHi  = n > nHi;
    nBelowMin = n < {1'b0, nMin};
    nAboveMax = n > {1'b0, nMax};
    mLast     = m >= mMax;
    plLast    = pl >= hiCode;
    plEmpty   = loCode > hiCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgt <= '0; refR <= '0; pad <= '0; vco <= '0;
      hiCode <= '0; loCode <= '0; pl <= '0; m <= '0; n <= '0; nHi <= '0;
      bestM <= '0; bestN <= '0; bestPl <= '0; bestDelta <= '1; rateR <= '0;
    end else begin
      if (s.clear) begin
        tgt       <= DW'({targetKhz, 1'b0});
        refR      <= DW'(refKhz);
        bestM     <= mMax;
        bestN     <= nMin;
        bestPl    <= CODE_W'(RMIN);
        bestDelta <= '1;
      end
      if (s.take) begin
        unique case (s.op)
          OP_PAD:  pad    <= tgt + quot;
          OP_HI:   hiCode <= codeFor(clampRatio(quot));
          OP_LO:   loCode <= codeFor(clampRatio(quot));
          OP_NF: begin
            n   <= quot[NHW-1:0];
            nHi <= quot[NHW-1:0] + NHW'(remd != '0);
          end
          OP_VCO:  vco <= quot;
          OP_LWV: if (delta < bestDelta) begin
            bestDelta <= delta;
            bestM     <= m;
            bestN     <= n[NW-1:0];
            bestPl    <= pl;
          end
          OP_RATE: rateR <= FW'(quot >> 1);
          default: ;
        endcase
      end
      if (s.plLoad)     pl <= loCode;
      else if (s.plInc) pl <= pl + 1'b1;
      if (s.mLoad)      m <= mMin;
      else if (s.mInc)  m <= m + 1'b1;
      if (s.nInc)       n <= n + 1'b1;
    end
  end

  assign mOut    = bestM;
  assign nOut    = bestN;
  assign plOut   = bestPl;
  assign rateKhz = rateR;
  assign exact   = (bestDelta == '0);
endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       divDone,
  input  logic       qLtCmpMin,
  input  logic       qGtCmpMax,
  input  logic       qGtNMax,
  input  logic       qInVco,
  input  logic       hitZero,
  input  logic       nAboveHi,
  input  logic       nBelowMin,
  input  logic       nAboveMax,
  input  logic       mLast,
  input  logic       plLast,
  input  logic       plEmpty,
  output ctlStrobe_t s,
  output logic       busy,
  output logic       done
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_PAD, ST_HI, ST_LO, ST_PLSET, ST_CMP, ST_NF, ST_NCHK,
    ST_VCO, ST_LWV, ST_MNEXT, ST_PLNEXT, ST_RATE, ST_DONE
  } state_e;

  state_e state, nxt;
  logic   issued, isDiv, ready;

  always_comb begin
    s     = '0;
    nxt   = state;
    isDiv = 1'b1;
    unique case (state)
      ST_PAD:  s.op = OP_PAD;
      ST_HI:   s.op = OP_HI;
      ST_LO:   s.op = OP_LO;
      ST_CMP:  s.op = OP_CMP;
      ST_NF:   s.op = OP_NF;
      ST_VCO:  s.op = OP_VCO;
      ST_LWV:  s.op = OP_LWV;
      ST_RATE: s.op = OP_RATE;
      default: isDiv = 1'b0;
    endcase
    ready   = isDiv && issued && divDone;
    s.divGo = isDiv && !issued;
    s.take  = ready;
    unique case (state)
      ST_IDLE: if (start) begin s.clear = 1'b1; nxt = ST_PAD; end
      ST_PAD:  if (ready) nxt = ST_HI;
      ST_HI:   if (ready) nxt = ST_LO;
      ST_LO:   if (ready) nxt = ST_PLSET;
      ST_PLSET:
        if (plEmpty) nxt = ST_RATE;
        else begin s.plLoad = 1'b1; s.mLoad = 1'b1; nxt = ST_CMP; end
      ST_CMP: if (ready) begin
        if (qLtCmpMin)      nxt = ST_PLNEXT;
        else if (qGtCmpMax) nxt = ST_MNEXT;
        else                nxt = ST_NF;
      end
      ST_NF: if (ready) nxt = qGtNMax ? ST_PLNEXT : ST_NCHK;
      ST_NCHK:
        if (nAboveHi)       nxt = ST_MNEXT;
        else if (nBelowMin) s.nInc = 1'b1;
        else if (nAboveMax) nxt = ST_MNEXT;
        else                nxt = ST_VCO;
      ST_VCO: if (ready) begin
        if (qInVco) nxt = ST_LWV;
        else begin s.nInc = 1'b1; nxt = ST_NCHK; end
      end
      ST_LWV: if (ready) begin
        if (hitZero) nxt = ST_RATE;
        else begin s.nInc = 1'b1; nxt = ST_NCHK; end
      end
      ST_MNEXT:
        if (mLast) nxt = ST_PLNEXT;
        else begin s.mInc = 1'b1; nxt = ST_CMP; end
      ST_PLNEXT:
        if (plLast) nxt = ST_RATE;
        else begin s.plInc = 1'b1; s.mLoad = 1'b1; nxt = ST_CMP; end
      ST_RATE: if (ready) nxt = ST_DONE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      state  <= nxt;
      issued <= isDiv && !ready;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pcs_pkg::*;
#(
  parameter int unsigned FW   = 24,
  parameter int unsigned MW   = 8,
  parameter int unsigned NW   = 8,
  parameter int unsigned RMIN = 1,
  parameter int unsigned RMAX = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [FW-1:0] targetKhz,
  input  logic [FW-1:0] refKhz,
  input  logic [FW-1:0] vcoMinKhz,
  input  logic [FW-1:0] vcoMaxKhz,
  input  logic [FW-1:0] cmpMinKhz,
  input  logic [FW-1:0] cmpMaxKhz,
  input  logic [MW-1:0] mMin,
  input  logic [MW-1:0] mMax,
  input  logic [NW-1:0] nMin,
  input  logic [NW-1:0] nMax,
  output logic          busy,
  output logic          done,
  output logic [MW-1:0] mOut,
  output logic [NW-1:0] nOut,
  output logic [3:0]    plOut,
  output logic [FW-1:0] rateKhz,
  output logic          exact
);
  ctlStrobe_t strb;
  logic divDone, qLtCmpMin, qGtCmpMax, qGtNMax, qInVco, hitZero;
  logic nAboveHi, nBelowMin, nAboveMax, mLast, plLast, plEmpty;

  pcs_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .divDone(divDone),
    .qLtCmpMin(qLtCmpMin), .qGtCmpMax(qGtCmpMax), .qGtNMax(qGtNMax),
    .qInVco(qInVco), .hitZero(hitZero), .nAboveHi(nAboveHi),
    .nBelowMin(nBelowMin), .nAboveMax(nAboveMax), .mLast(mLast),
    .plLast(plLast), .plEmpty(plEmpty), .s(strb), .busy(busy), .done(done)
  );

  pcs_dpath #(.FW(FW), .MW(MW), .NW(NW), .RMIN(RMIN), .RMAX(RMAX)) uDpath (
    .clk(clk), .rstN(rstN), .s(strb),
    .targetKhz(targetKhz), .refKhz(refKhz),
    .vcoMinKhz(vcoMinKhz), .vcoMaxKhz(vcoMaxKhz),
    .cmpMinKhz(cmpMinKhz), .cmpMaxKhz(cmpMaxKhz),
    .mMin(mMin), .mMax(mMax), .nMin(nMin), .nMax(nMax),
    .divDone(divDone), .qLtCmpMin(qLtCmpMin), .qGtCmpMax(qGtCmpMax),
    .qGtNMax(qGtNMax), .qInVco(qInVco), .hitZero(hitZero),
    .nAboveHi(nAboveHi), .nBelowMin(nBelowMin), .nAboveMax(nAboveMax),
    .mLast(mLast), .plLast(plLast), .plEmpty(plEmpty),
    .mOut(mOut), .nOut(nOut), .plOut(plOut), .rateKhz(rateKhz), .exact(exact)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int unsigned FW = 24,
  parameter int unsigned MW = 8,
  parameter int unsigned NW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [MW-1:0] mOut,
  input logic [NW-1:0] nOut,
  input logic [3:0]    plOut,
  input logic [FW-1:0] rateKhz,
  input logic          exact,
  input logic [MW-1:0] mMin,
  input logic [MW-1:0] mMax,
  input logic [NW-1:0] nMin,
  input logic [NW-1:0] nMax
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable({mOut, nOut, plOut, rateKhz, exact}));

  // R11
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R5
  n_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (nOut >= nMin && nOut <= nMax));

  // R4
  m_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (mOut >= mMin && mOut <= mMax));

  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> plOut <= 4'd14);
endmodule

bind pll_coef_search pcs_checker uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .mOut(mOut), .nOut(nOut), .plOut(plOut), .rateKhz(rateKhz), .exact(exact),
  .mMin(mMin), .mMax(mMax), .nMin(nMin), .nMax(nMax)
);

// File: tb/pll_coef_search_test.sv
module pll_coef_search_test;
  localparam int FW = 24;
  localparam int MW = 8;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [FW-1:0] targetKhz = '0;
  logic [FW-1:0] refKhz = '0;
  logic [FW-1:0] vcoMinKhz = FW'(1000000);
  logic [FW-1:0] vcoMaxKhz = FW'(2064000);
  logic [FW-1:0] cmpMinKhz = FW'(12000);
  logic [FW-1:0] cmpMaxKhz = FW'(38000);
  logic [MW-1:0] mMin = MW'(1);
  logic [MW-1:0] mMax = MW'(255);
  logic [NW-1:0] nMin = NW'(8);
  logic [NW-1:0] nMax = NW'(255);
  logic busy, done, exact;
  logic [MW-1:0] mOut;
  logic [NW-1:0] nOut;
  logic [3:0] plOut;
  logic [FW-1:0] rateKhz;

  int checks = 0;
  int failures = 0;
  longint cyc = 0;

  pll_coef_search uut (
    .clk(clk), .rstN(rstN), .start(start), .targetKhz(targetKhz), .refKhz(refKhz),
    .vcoMinKhz(vcoMinKhz), .vcoMaxKhz(vcoMaxKhz), .cmpMinKhz(cmpMinKhz),
    .cmpMaxKhz(cmpMaxKhz), .mMin(mMin), .mMax(mMax), .nMin(nMin), .nMax(nMax),
    .busy(busy), .done(done), .mOut(mOut), .nOut(nOut), .plOut(plOut),
    .rateKhz(rateKhz), .exact(exact)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cyc >= 190000);
    checks++;
    failures++;
    $display("FAIL R10 watchdog actual=no finish expected=finish");
    summary();
  end

  function automatic longint tbRatio(input longint c);
    case (c)
      0: return 1;   1: return 2;   2: return 3;   3: return 4;
      4: return 5;   5: return 6;   6: return 8;   7: return 10;
      8: return 12;  9: return 16;  10: return 12; 11: return 16;
      12: return 20; 13: return 24; 14: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic longint tbCode(input longint r);
    for (int c = 0; c < 14; c++) if (tbRatio(c) >= r) return c;
    return 14;
  endfunction

  function automatic longint clampR(input longint v);
    if (v < 1) return 1;
    if (v > 32) return 32;
    return v;
  endfunction

  // Expected result from the requirement text (R2..R9)
  task automatic model(input longint rate, input longint rf,
                       output longint em, output longint en, output longint ep,
                       output longint er, output bit ee);
    longint t, tv, vmx, hiC, loC, bd, r, nf, nc, v, lwv, d;
    bit stop;
    t = 2 * rate;
    tv = t + t / 50;
    vmx = (longint'(vcoMaxKhz) > tv) ? longint'(vcoMaxKhz) : tv;
    hiC = tbCode(clampR((vmx + tv - 1) / tv));
    loC = tbCode(clampR(longint'(vcoMinKhz) / tv));
    bd = 64'h7fffffffffffffff;
    em = longint'(mMax); en = longint'(nMin); ep = 1; stop = 1'b0;
    for (longint pl = loC; pl <= hiC && !stop; pl++) begin
      r = tbRatio(pl);
      for (longint m = longint'(mMin); m <= longint'(mMax) && !stop; m++) begin
        if (rf / m < longint'(cmpMinKhz)) break;
        if (rf / m > longint'(cmpMaxKhz)) continue;
        nf = t * r * m / rf;
        nc = (t * r * m + rf - 1) / rf;
        if (nf > longint'(nMax)) break;
        for (longint n = nf; n <= nc && !stop; n++) begin
          if (n < longint'(nMin)) continue;
          if (n > longint'(nMax)) break;
          v = rf * n / m;
          if (v >= longint'(vcoMinKhz) && v <= vmx) begin
            lwv = (v + r / 2) / r;
            d = (lwv > t) ? lwv - t : t - lwv;
            if (d < bd) begin
              bd = d; em = m; en = n; ep = pl;
              if (d == 0) stop = 1'b1;
            end
          end
        end
      end
    end
    er = (rf * en / (em * tbRatio(ep))) / 2;
    ee = (bd == 0);
  endtask

  task automatic runCase(input longint rate, input longint rf, input bit disturb,
                         input string tag);
    longint em, en, ep, er;
    bit ee;
    int waitCnt;
    model(rate, rf, em, en, ep, er, ee);
    @(negedge clk);
    targetKhz = FW'(rate);
    refKhz = FW'(rf);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0,
          $sformatf("R10 busy after start actual busy=%0b done=%0b expected busy=1 done=0", busy, done));
    if (disturb) begin
      repeat (5) @(negedge clk);
      targetKhz = FW'(rate + 12345);
      refKhz = FW'(rf + 1000);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitCnt = 0;
    while (done !== 1'b1 && waitCnt < 30000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done === 1'b1, $sformatf("R10 %s no done actual=timeout expected=done", tag));
    check(longint'(mOut) == em && longint'(nOut) == en && longint'(plOut) == ep &&
          rateKhz == FW'(er) && exact == ee,
          $sformatf("%s rate=%0d ref=%0d actual m=%0d n=%0d pl=%0d f=%0d ex=%0b expected m=%0d n=%0d pl=%0d f=%0d ex=%0b",
                    tag, rate, rf, mOut, nOut, plOut, rateKhz, exact, em, en, ep, FW'(er), ee));
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0,
          $sformatf("R10 pulse width actual done=%0b busy=%0b expected done=0 busy=0", done, busy));
    repeat (3) @(negedge clk);
    check(longint'(mOut) == em && longint'(nOut) == en && rateKhz == FW'(er),
          $sformatf("R10 hold actual m=%0d n=%0d f=%0d expected m=%0d n=%0d f=%0d",
                    mOut, nOut, rateKhz, em, en, FW'(er)));
  endtask

  longint refs[3] = '{12000, 19200, 38400};
  longint rates[7] = '{20000, 72000, 144000, 300000, 540000, 852000, 1100000};

  initial begin
    repeat (3) @(negedge clk);
    check(done === 1'b0 && busy === 1'b0 && mOut === '0 && nOut === '0 &&
          plOut === '0 && rateKhz === '0 && exact === 1'b0,
          $sformatf("R10 reset actual done=%0b busy=%0b m=%0d n=%0d pl=%0d f=%0d ex=%0b expected all 0",
                    done, busy, mOut, nOut, plOut, rateKhz, exact));
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R6 R7 R9: sweep of references and requests under default limits
    foreach (refs[i]) begin
      foreach (rates[j]) begin
        runCase(rates[j], refs[i], 1'b0, "R1/R2/R3/R6/R7/R9 sweep");
      end
    end

    // R11: restart and input change while busy must not disturb the search
    runCase(144000, 38400, 1'b1, "R11 start while busy");

    // R4: narrow comparison window so low M values are skipped
    cmpMaxKhz = FW'(15000);
    runCase(300000, 38400, 1'b0, "R4 cmp skip");
    runCase(72000, 19200, 1'b0, "R4 cmp break");
    cmpMaxKhz = FW'(38000);

    // R5: raised nMin skips small N values
    nMin = NW'(100);
    runCase(72000, 38400, 1'b0, "R5 nMin skip");
    nMin = NW'(8);

    // R8: nMax too small for any candidate
    nMax = NW'(10);
    runCase(540000, 12000, 1'b0, "R8 fallback");
    check(mOut == MW'(255) && nOut == NW'(8) && plOut == 4'd1 && exact == 1'b0,
          $sformatf("R8 fallback fields actual m=%0d n=%0d pl=%0d ex=%0b expected m=255 n=8 pl=1 ex=0",
                    mOut, nOut, plOut, exact));
    nMax = NW'(255);

    summary();
  end
endmodule